// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block is the controller-side engine that takes a DDR2 SDRAM device from a cold start to a usable state. After a synchronous reset it holds the clock-enable low through the power-settling interval. It then raises clock-enable and waits out the stabilization time. Finally it plays out a fixed series of one-cycle commands on a small command/address bus: precharge-all, mode-register loads, refresh. Each delay is a cycle count derived at elaboration time from a clock-frequency parameter and nanosecond or microsecond figures.

The four mode-register payloads enter as plain 13-bit configuration ports. Callers own most of each payload. The sequencer itself owns the bits whose value depends on the step: the DLL-reset bit of the main mode register, and the DLL-disable and off-chip-driver calibration fields of extended register 1. Nothing streams through the block, so there is no valid/ready handshake. Every pin is a plain control or status level, and the command bus carries a NOP encoding whenever no command is being issued.

When the last load has settled, the block pulses a one-cycle completion flag and raises a ready level. The ready level holds until the next reset. A reset at any point restarts the whole sequence from the power wait.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: While reset is applied and in the cycle after it, cke is 0, cmd is NOP, ba and addr are 0, and init_done and init_ready are 0. After reset is released, cke stays 0 for exactly PWRUP_US*CLK_MHZ cycles, then rises and stays high until the next reset.
- R2: The first command is a precharge-all issued exactly ceil(CKE_NS*CLK_MHZ/1000) cycles after cke rises. No command other than NOP appears while cke is low.
- R3: The command encoding on cmd is 0 = NOP, 1 = precharge-all, 2 = mode-register load, 3 = refresh. During NOP and refresh, ba and addr are 0. During precharge-all, ba is 0 and addr is 16'h0400 (A10 high).
- R4: The non-NOP commands come in exactly this order: precharge, load BA=2, load BA=3, load BA=1, load BA=0, precharge, refresh, refresh, load BA=0, load BA=1, load BA=1. No further command follows.
- R5: A load drives ba[1:0] to select the register (0 main, 1 extended 1, 2 extended 2, 3 extended 3). It keeps ba[2] and addr[15:13] at 0 and places the register payload on addr[12:0]. The extended-2 and extended-3 loads carry emr2_cfg and emr3_cfg unchanged.
- R6: All three extended-1 loads carry emr1_cfg with bit 0 cleared (DLL enabled). The first and third also clear bits [9:7]. The second sets bits [9:7] to 111 (calibration default), so the third is the calibration exit.
- R7: The first main-register load carries mr_cfg with bit 8 set (DLL reset). The second carries mr_cfg with bit 8 cleared.
- R8: The spacing between one command and the next is exact. It is ceil(T_RP_NS*CLK_MHZ/1000) cycles after a precharge, ceil(T_RFC_NS*CLK_MHZ/1000) after a refresh, and T_MRD_CK after a load. Each of these is raised to 2 if smaller.
- R9: The precharge that follows the DLL-reset load comes exactly max(DLL_CK, load spacing) cycles after that load.
- R10: Every command lasts one cycle and is followed by at least one NOP cycle.
- R11: init_done is high for exactly one cycle, one load spacing after the final extended-1 load. init_ready rises in the same cycle, and from then on it stays high with cmd held at NOP until reset.
- R12: A synchronous reset applied mid-sequence drops cke and returns the bus to NOP on the next edge. After release, the full sequence restarts with all timing counted afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, CLK_MHZ nominal |
| rst | input | 1 | Synchronous active-high reset, restarts the power wait |
| mr_cfg | input | 13 | Main mode-register payload (bit 8 overridden) |
| emr1_cfg | input | 13 | Extended register 1 payload (bits 9:7 and 0 overridden) |
| emr2_cfg | input | 13 | Extended register 2 payload |
| emr3_cfg | input | 13 | Extended register 3 payload |
| cke | output | 1 | SDRAM clock enable |
| cmd | output | 2 | Command code: 0 NOP, 1 precharge-all, 2 mode load, 3 refresh |
| ba | output | 3 | Bank address; register select during loads |
| addr | output | 16 | Address bus; register payload during loads |
| init_done | output | 1 | One-cycle pulse when the sequence completes |
| init_ready | output | 1 | Held high after completion until reset |

## Verification
The properties assume that rst is a clean synchronous level and that the four configuration ports hold steady from reset release until completion, since a load copies whatever value is present in its issue cycle. The stimulus therefore changes the configuration only while reset is held, including in the mid-sequence restart. It picks patterns with the overridden bits both set and clear, so that the forced fields are visible at the pins. The timing parameters are shortened at the power wait only, and every resulting gap stays at or above two cycles, as the single-cycle-command property expects.

// File: rtl/ddr2_bringup_pkg.sv
package ddr2_bringup_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_LMR  = 2'd2,
    CMD_REF  = 2'd3
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    GAP_MRD,
    GAP_RP,
    GAP_RFC,
    GAP_DLL
  } gap_kind_e;

  typedef enum logic [1:0] {
    PH_POWER,
    PH_SETTLE,
    PH_RUN,
    PH_READY
  } phase_e;

  typedef struct packed {
    sdram_cmd_e cmd;
    logic [1:0] bank;
    logic [12:0] row;
    gap_kind_e  gap;
  } step_t;

  localparam int unsigned NUM_STEPS = 11;

  // Payload bits the sequencer owns
  localparam logic [12:0] ROW_DLL_OFF = 13'h0001;
  localparam logic [12:0] ROW_OCD     = 13'h0380;
  localparam logic [12:0] ROW_DLL_RST = 13'h0100;
  localparam logic [12:0] ROW_ALLBANK = 13'h0400;

  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int unsigned at_least(int unsigned v, int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/ddr2_delay_timer.sv
module ddr2_delay_timer #(
  parameter int unsigned W         = 16,
  parameter int unsigned RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= W'(RESET_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R8: the count falls by one per idle cycle, so gaps are exact
  p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R11: once empty and not reloaded, the counter stays empty
  p_hold_empty_r11: assert property (@(posedge clk) disable iff (rst)
    (!load && zero) |=> zero);

endmodule

// File: rtl/ddr2_step_rom.sv
module ddr2_step_rom
  import ddr2_bringup_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [12:0]      mr_cfg,
  input  logic [12:0]      emr1_cfg,
  input  logic [12:0]      emr2_cfg,
  input  logic [12:0]      emr3_cfg,
  output step_t            step
);

  logic [12:0] e1_base;
  logic [12:0] mr_on;
  logic [12:0] mr_off;

  assign e1_base = emr1_cfg & ~(ROW_DLL_OFF | ROW_OCD);
  assign mr_on   = mr_cfg | ROW_DLL_RST;
  assign mr_off  = mr_cfg & ~ROW_DLL_RST;

  always_comb begin
    step = '{cmd: CMD_NOP, bank: 2'd0, row: 13'd0, gap: GAP_MRD};
    case (idx)
      IDX_W'(0):  step = '{cmd: CMD_PREA, bank: 2'd0, row: ROW_ALLBANK,        gap: GAP_RP};
      IDX_W'(1):  step = '{cmd: CMD_LMR,  bank: 2'd2, row: emr2_cfg,           gap: GAP_MRD};
      IDX_W'(2):  step = '{cmd: CMD_LMR,  bank: 2'd3, row: emr3_cfg,           gap: GAP_MRD};
      IDX_W'(3):  step = '{cmd: CMD_LMR,  bank: 2'd1, row: e1_base,            gap: GAP_MRD};
      IDX_W'(4):  step = '{cmd: CMD_LMR,  bank: 2'd0, row: mr_on,              gap: GAP_DLL};
      IDX_W'(5):  step = '{cmd: CMD_PREA, bank: 2'd0, row: ROW_ALLBANK,        gap: GAP_RP};
      IDX_W'(6):  step = '{cmd: CMD_REF,  bank: 2'd0, row: 13'd0,              gap: GAP_RFC};
      IDX_W'(7):  step = '{cmd: CMD_REF,  bank: 2'd0, row: 13'd0,              gap: GAP_RFC};
      IDX_W'(8):  step = '{cmd: CMD_LMR,  bank: 2'd0, row: mr_off,             gap: GAP_MRD};
      IDX_W'(9):  step = '{cmd: CMD_LMR,  bank: 2'd1, row: e1_base | ROW_OCD,  gap: GAP_MRD};
      IDX_W'(10): step = '{cmd: CMD_LMR,  bank: 2'd1, row: e1_base,            gap: GAP_MRD};
      default:    ;
    endcase
  end

endmodule

// File: rtl/ddr2_bringup_seq.sv
module ddr2_bringup_seq
  import ddr2_bringup_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 250,
  parameter int unsigned PWRUP_US = 200,
  parameter int unsigned CKE_NS   = 400,
  parameter int unsigned T_RP_NS  = 15,
  parameter int unsigned T_RFC_NS = 128,
  parameter int unsigned T_MRD_CK = 2,
  parameter int unsigned DLL_CK   = 200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [12:0] mr_cfg,
  input  logic [12:0] emr1_cfg,
  input  logic [12:0] emr2_cfg,
  input  logic [12:0] emr3_cfg,
  output logic        cke,
  output logic [1:0]  cmd,
  output logic [2:0]  ba,
  output logic [15:0] addr,
  output logic        init_done,
  output logic        init_ready
);

  localparam int unsigned PWR_CYC = at_least(PWRUP_US * CLK_MHZ, 1);
  localparam int unsigned CKE_CYC = at_least(ns_to_cycles(CKE_NS, CLK_MHZ), 1);
  localparam int unsigned RP_CYC  = at_least(ns_to_cycles(T_RP_NS, CLK_MHZ), 2);
  localparam int unsigned RFC_CYC = at_least(ns_to_cycles(T_RFC_NS, CLK_MHZ), 2);
  localparam int unsigned MRD_CYC = at_least(T_MRD_CK, 2);
  localparam int unsigned DLL_CYC = at_least(DLL_CK, MRD_CYC);
  localparam int unsigned MAX_CYC = at_least(at_least(at_least(PWR_CYC, CKE_CYC),
                                    at_least(RP_CYC, RFC_CYC)), DLL_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned IDX_W   = $clog2(NUM_STEPS + 1);
  localparam logic [IDX_W-1:0] END_IDX = IDX_W'(NUM_STEPS);

  phase_e           phase;
  logic [IDX_W-1:0] idx;
  step_t            step;
  logic             t_zero;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic [CNT_W-1:0] gap_len;

  sdram_cmd_e  cmd_q;
  logic [2:0]  ba_q;
  logic [15:0] addr_q;
  logic        cke_q;
  logic        done_q;
  logic        ready_q;

  ddr2_step_rom #(.IDX_W(IDX_W)) u_rom (
    .idx      (idx),
    .mr_cfg   (mr_cfg),
    .emr1_cfg (emr1_cfg),
    .emr2_cfg (emr2_cfg),
    .emr3_cfg (emr3_cfg),
    .step     (step)
  );

  always_comb begin
    case (step.gap)
      GAP_RP:  gap_len = CNT_W'(RP_CYC);
      GAP_RFC: gap_len = CNT_W'(RFC_CYC);
      GAP_DLL: gap_len = CNT_W'(DLL_CYC);
      default: gap_len = CNT_W'(MRD_CYC);
    endcase
  end

  // Reload the timer whenever an interval ends and another one begins
  always_comb begin
    t_load = 1'b0;
    t_val  = gap_len - 1'b1;
    if (t_zero) begin
      case (phase)
        PH_POWER: begin
          t_load = 1'b1;
          t_val  = CNT_W'(CKE_CYC - 1);
        end
        PH_SETTLE: t_load = 1'b1;
        PH_RUN:    t_load = (idx != END_IDX);
        default:   t_load = 1'b0;
      endcase
    end
  end

  ddr2_delay_timer #(.W(CNT_W), .RESET_VAL(PWR_CYC - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_POWER;
      idx     <= '0;
      cke_q   <= 1'b0;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      case (phase)
        PH_POWER: if (t_zero) begin
          cke_q <= 1'b1;
          phase <= PH_SETTLE;
        end
        PH_SETTLE, PH_RUN: if (t_zero) begin
          if (phase == PH_RUN && idx == END_IDX) begin
            done_q  <= 1'b1;
            ready_q <= 1'b1;
            phase   <= PH_READY;
          end else begin
            cmd_q  <= step.cmd;
            ba_q   <= {1'b0, step.bank};
            addr_q <= {3'b000, step.row};
            idx    <= idx + 1'b1;
            phase  <= PH_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  assign cke        = cke_q;
  assign cmd        = cmd_q;
  assign ba         = ba_q;
  assign addr       = addr_q;
  assign init_done  = done_q;
  assign init_ready = ready_q;

  // R1: clock enable never drops once raised, short of reset
  p_cke_hold_r1: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  // R2: the bus stays idle while clock enable is low
  p_idle_cke_low_r2: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cmd == CMD_NOP));

  // R3: precharge-all drives A10 only
  p_prea_a10_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PREA) |-> (addr == 16'h0400 && ba == 3'd0));

  // R5: loads keep the unused high address and bank lines low
  p_load_high_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LMR) |-> (ba[2] == 1'b0 && addr[15:13] == 3'd0));

  // R10: each command lasts a single cycle
  p_one_cycle_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

  // R11: completion pulse is one cycle wide and leaves ready high
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    init_done |=> (!init_done && init_ready));

  // R11: ready holds with an idle bus
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
    init_ready |=> (init_ready && cmd == CMD_NOP));

endmodule

// File: tb/sim_ddr2_bringup_seq.sv
module sim_ddr2_bringup_seq;

  // Expected timing from the requirements with the bench parameters
  localparam int P   = 500;  // 2 us at 250 MHz
  localparam int C   = 100;  // 400 ns at 250 MHz
  localparam int RP  = 4;    // ceil(15 ns * 0.25)
  localparam int RFC = 32;   // ceil(128 ns * 0.25)
  localparam int MRD = 2;
  localparam int DLL = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] mr_cfg = '0, emr1_cfg = '0, emr2_cfg = '0, emr3_cfg = '0;
  logic        cke, init_done, init_ready;
  logic [1:0]  cmd;
  logic [2:0]  ba;
  logic [15:0] addr;

  always #2 clk = ~clk;

  ddr2_bringup_seq #(
    .CLK_MHZ(250), .PWRUP_US(2), .CKE_NS(400), .T_RP_NS(15),
    .T_RFC_NS(128), .T_MRD_CK(2), .DLL_CK(200)
  ) u0 (
    .clk(clk), .rst(rst), .mr_cfg(mr_cfg), .emr1_cfg(emr1_cfg),
    .emr2_cfg(emr2_cfg), .emr3_cfg(emr3_cfg), .cke(cke), .cmd(cmd),
    .ba(ba), .addr(addr), .init_done(init_done), .init_ready(init_ready)
  );

  typedef struct {
    int          cyc;
    logic [1:0]  cmd;
    logic [2:0]  ba;
    logic [15:0] addr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   done_at = 0;
  bit   finished = 1'b0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push(int c, logic [1:0] k, logic [2:0] b, logic [15:0] a, string tag);
    exp_t e;
    e.cyc = c; e.cmd = k; e.ba = b; e.addr = a; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver side of the scoreboard: the full expected command list
  task automatic plan(logic [12:0] mr, logic [12:0] e1, logic [12:0] e2, logic [12:0] e3);
    int t;
    logic [12:0] e1b;
    e1b = e1 & ~13'h0381;
    t = P + C;
    push(t, 2'd1, 3'd0, 16'h0400, "R2 R3 first precharge");
    t += RP;  push(t, 2'd2, 3'd2, {3'b0, e2}, "R4 R5 R8 ext2 load");
    t += MRD; push(t, 2'd2, 3'd3, {3'b0, e3}, "R4 R5 ext3 load");
    t += MRD; push(t, 2'd2, 3'd1, {3'b0, e1b}, "R6 ext1 DLL on");
    t += MRD; push(t, 2'd2, 3'd0, {3'b0, mr | 13'h0100}, "R7 main DLL reset");
    t += DLL; push(t, 2'd1, 3'd0, 16'h0400, "R9 second precharge");
    t += RP;  push(t, 2'd3, 3'd0, 16'h0000, "R8 refresh one");
    t += RFC; push(t, 2'd3, 3'd0, 16'h0000, "R8 refresh two");
    t += RFC; push(t, 2'd2, 3'd0, {3'b0, mr & ~13'h0100}, "R7 main no DLL reset");
    t += MRD; push(t, 2'd2, 3'd1, {3'b0, e1b | 13'h0380}, "R6 calibration default");
    t += MRD; push(t, 2'd2, 3'd1, {3'b0, e1b}, "R6 calibration exit");
    done_at = t + MRD;
  endtask

  // Monitor side: pop and compare every issued command
  always @(negedge clk) begin
    if (!rst && !finished && cmd != 2'd0) begin
      if (q.size() == 0) begin
        check(1'b0, "R4", "unexpected command", cmd, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.cyc, e.tag, "issue cycle", cyc, e.cyc);
        check(cmd == e.cmd, e.tag, "command code", cmd, e.cmd);
        check(ba == e.ba, e.tag, "bank lines", ba, e.ba);
        check(addr == e.addr, e.tag, "address lines", addr, e.addr);
      end
    end
  end

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic start(logic [12:0] mr, logic [12:0] e1, logic [12:0] e2,
                       logic [12:0] e3, string tag);
    @(negedge clk);
    rst = 1'b1;
    mr_cfg = mr; emr1_cfg = e1; emr2_cfg = e2; emr3_cfg = e3;
    @(negedge clk);
    check(cke == 1'b0, tag, "cke in reset", cke, 0);
    @(negedge clk);
    check(cmd == 2'd0 && ba == 3'd0 && addr == 16'd0, tag, "bus in reset",
          {cmd, ba, addr}, 0);
    check(!init_done && !init_ready, tag, "flags in reset",
          {init_done, init_ready}, 0);
    q.delete();
    plan(mr, e1, e2, e3);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    wait_cyc(P - 1);
    check(cke == 1'b0, "R1", "cke before power wait ends", cke, 0);
    wait_cyc(P);
    check(cke == 1'b1, "R1", "cke after power wait", cke, 1);
    wait_cyc(done_at - 1);
    check(!init_done && !init_ready, "R11", "flags before completion",
          {init_done, init_ready}, 0);
    wait_cyc(done_at);
    check(init_done && init_ready, "R11", "flags at completion",
          {init_done, init_ready}, 3);
    wait_cyc(done_at + 1);
    check(!init_done && init_ready, "R11", "pulse width and ready hold",
          {init_done, init_ready}, 1);
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R4", "commands left unissued", q.size(), 0);
    check(init_ready && cmd == 2'd0 && cke, "R11", "idle ready state",
          {init_ready, cmd, cke}, 3'b101);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // Ordinary payloads, forced bits clear on input
    start(13'h0A42, 13'h0044, 13'h0080, 13'h0005, "R1");
    finish_run();
    // All-ones payloads, so every forced clear shows at the pins
    start(13'h1FFF, 13'h1FFF, 13'h1FFF, 13'h1FFF, "R1");
    finish_run();
    // Restart in the middle of the load sequence
    start(13'h0153, 13'h0381, 13'h1000, 13'h0ABC, "R1");
    wait_cyc(P + C + 30);
    start(13'h0A5A, 13'h0246, 13'h0003, 13'h1555, "R12");
    finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule